// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The router collects level requests from a set of device interrupt lines into one shared request vector and hands each CPU the subset it has enabled. Device logic raises or lowers a line with a one-cycle strobe that carries the line number. Every CPU owns an enable mask. Its pending vector is the shared request vector ANDed with that mask, and its interrupt output is asserted while any of its pending bits is set. Software reaches the block through a 64-bit register port. Through that port it reads the shared vector, every mask and every pending vector, and writes the masks.

A mask write affects pending bits one line at a time. Enabling a line that is already requested makes it pending for that CPU on the next cycle. Disabling a line withdraws it from that CPU on the next cycle. A device event and a mask write in the same cycle are merged. The device event is applied to the request vector first, and the pending vector is then formed from the new vector and the new mask.

The register port uses a small three-state machine: `CSR_IDLE`, `CSR_READ_RESP` and `CSR_FAULT_RESP`. From any state, an access moves the machine as follows:
- a legal read goes to `CSR_READ_RESP`;
- an illegal access goes to `CSR_FAULT_RESP`;
- a legal write, or a cycle with no access, goes to `CSR_IDLE`.

`CSR_READ_RESP` drives the read-valid pulse and `CSR_FAULT_RESP` drives the error pulse. Each of these states lasts one cycle unless another access follows it.

Top module: `intr_router`

## Requirements
- R1: A set strobe for line n makes bit n of the shared request vector 1 from the next clock edge on. The shared vector reads back at register index 0.
- R2: A clear strobe for line n makes request bit n 0 from the next edge. When a set and a clear name the same line in one cycle, the set wins and the bit ends as 1.
- R3: A clear strobe for a line whose request bit is already 0 is spurious. It changes no state, and `dev_clr_spurious` is 1 for exactly the following cycle.
- R4: Each CPU's pending vector equals the request vector ANDed with that CPU's mask. It follows any request or mask change one cycle after the causing edge. A same-cycle device event and mask write both take effect in the result.
- R5: `cpu_irq[c]` is 1 exactly when CPU c's pending vector is nonzero, and it changes in the same cycle as that vector.
- R6: The register index is the byte address shifted right by 6, and the low 6 address bits must be 0. The map is as follows:
  - index 0 is the request vector, read only;
  - indices 1 to NUM_CPUS are the masks of CPU 0 upward, read and write;
  - indices NUM_CPUS+1 to 2*NUM_CPUS are the pending vectors of CPU 0 upward, read only;
  - every other index is unmapped.
- R7: A legal read pulses `csr_rvalid` for one cycle after the access. `csr_rdata` carries the register value as it stood during the access cycle.
- R8: `csr_size` gives the access width as log2 of the byte count, and only the value 3 (8 bytes) is legal.
- R9: An illegal access pulses `csr_err` for one cycle after the access, changes no mask, and returns `csr_rdata` of 0. An illegal access is any of: an unmapped index, a misaligned offset, a narrow size, or a write to the request or pending vectors.
- R10: A legal mask write produces neither `csr_rvalid` nor `csr_err`. The new mask is in effect from the next edge.
- R11: After reset, the request vector, masks, pending vectors, interrupt outputs and all response flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_set | input | 1 | Raise-request strobe |
| dev_set_line | input | LINE_W | Line to raise |
| dev_clr | input | 1 | Lower-request strobe |
| dev_clr_line | input | LINE_W | Line to lower |
| dev_clr_spurious | output | 1 | Previous clear hit a line not requested |
| csr_valid | input | 1 | Register access this cycle |
| csr_write | input | 1 | 1 write, 0 read |
| csr_addr | input | ADDR_W | Byte offset |
| csr_size | input | 2 | log2 of access bytes |
| csr_wdata | input | NUM_LINES | Write data |
| csr_rdata | output | NUM_LINES | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read response pulse |
| csr_err | output | 1 | Illegal-access pulse |
| cpu_irq | output | NUM_CPUS | Per-CPU interrupt level |
| cpu_pending | output | NUM_CPUS*NUM_LINES | Per-CPU pending vectors, CPU c at bits c*NUM_LINES upward |

## Verification
The assertions assume the following about the inputs:
- line indices stay below NUM_LINES, which the default power-of-two line count guarantees;
- reset is held for at least one edge before any strobe is relied on;
- each strobe and each `csr_valid` pulse stands for exactly one event or access per cycle.

The stimulus draws every line index from the full index range. It overlaps set, clear and register traffic freely, including same-line set and clear. Register accesses are mostly legal, with misaligned, narrow, unmapped and read-only-write cases mixed in, so the response machine is exercised on every transition.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

    typedef enum logic [1:0] {
        CSR_IDLE,
        CSR_READ_RESP,
        CSR_FAULT_RESP
    } csr_state_e;

    typedef enum logic [1:0] {
        REG_RAW,
        REG_MASK,
        REG_PEND,
        REG_NONE
    } reg_kind_e;

    localparam logic [1:0] SIZE_DWORD = 2'd3;
    localparam int         STRIDE_SH  = 6;

endpackage

// File: rtl/intr_raw_vec.sv
module intr_raw_vec #(
    parameter int NUM_LINES = 64,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld,
    input  logic [LINE_W-1:0]    set_idx,
    input  logic                 clr_vld,
    input  logic [LINE_W-1:0]    clr_idx,
    output logic [NUM_LINES-1:0] raw_q,
    output logic [NUM_LINES-1:0] raw_next,
    output logic                 spur_q
);

    // Clear is applied first, so a set of the same line wins.
    always_comb begin
        raw_next = raw_q;
        if (clr_vld) raw_next[clr_idx] = 1'b0;
        if (set_vld) raw_next[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q  <= '0;
            spur_q <= 1'b0;
        end else begin
            raw_q  <= raw_next;
            spur_q <= clr_vld && !raw_q[clr_idx];
        end
    end

    p_set_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_vld |=> raw_q[$past(set_idx)]);

    p_clear_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !(set_vld && set_idx == clr_idx)) |=> !raw_q[$past(clr_idx)]);

    p_spurious_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !raw_q[clr_idx] && !set_vld) |=> (raw_q == $past(raw_q)) && spur_q);

endmodule

// File: rtl/intr_cpu_slice.sv
module intr_cpu_slice #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_next,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic                 irq_q
);

    logic [NUM_LINES-1:0] mask_next;
    logic [NUM_LINES-1:0] pend_next;

    assign mask_next = mask_we ? mask_wdata : mask_q;
    assign pend_next = raw_next & mask_next;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_next;
            pend_q <= pend_next;
            irq_q  <= |pend_next;
        end
    end

    p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (|pend_q));

    p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(mask_wdata));

endmodule

// File: rtl/intr_csr_ctrl.sv
module intr_csr_ctrl
    import intr_router_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = ADDR_W - STRIDE_SH,
    localparam int SEL_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          csr_valid,
    input  logic                          csr_write,
    input  logic [ADDR_W-1:0]             csr_addr,
    input  logic [1:0]                    csr_size,
    input  logic [NUM_LINES-1:0]          raw_q,
    input  logic [NUM_CPUS*NUM_LINES-1:0] mask_all,
    input  logic [NUM_CPUS*NUM_LINES-1:0] pend_all,
    output logic [NUM_CPUS-1:0]           mask_we,
    output logic [NUM_LINES-1:0]          rdata,
    output logic                          rvalid,
    output logic                          err
);

    csr_state_e           state_q, state_d;
    reg_kind_e            kind;
    logic [IDX_W-1:0]     idx;
    logic [SEL_W-1:0]     sel;
    logic                 aligned, legal;
    logic [NUM_LINES-1:0] rd_mux, rdata_q;

    assign idx     = csr_addr[ADDR_W-1:STRIDE_SH];
    assign aligned = (csr_addr[STRIDE_SH-1:0] == '0);

    always_comb begin
        kind = REG_NONE;
        sel  = '0;
        if (idx == '0) begin
            kind = REG_RAW;
        end else if (int'(idx) <= NUM_CPUS) begin
            kind = REG_MASK;
            sel  = SEL_W'(int'(idx) - 1);
        end else if (int'(idx) <= 2 * NUM_CPUS) begin
            kind = REG_PEND;
            sel  = SEL_W'(int'(idx) - 1 - NUM_CPUS);
        end
    end

    assign legal = csr_valid && aligned && (csr_size == SIZE_DWORD) &&
                   (kind != REG_NONE) && (!csr_write || kind == REG_MASK);

    always_comb begin
        unique case (kind)
            REG_RAW:  rd_mux = raw_q;
            REG_MASK: rd_mux = mask_all[sel*NUM_LINES +: NUM_LINES];
            REG_PEND: rd_mux = pend_all[sel*NUM_LINES +: NUM_LINES];
            default:  rd_mux = '0;
        endcase
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_we
        assign mask_we[c] = legal && csr_write && (kind == REG_MASK) &&
                            (sel == SEL_W'(c));
    end

    // Next state: the access of this cycle decides, whatever the current state.
    always_comb begin
        state_d = CSR_IDLE;
        if (csr_valid) begin
            if (!legal)         state_d = CSR_FAULT_RESP;
            else if (!csr_write) state_d = CSR_READ_RESP;
        end
    end

    // State register and captured read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CSR_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (legal && !csr_write) rdata_q <= rd_mux;
        end
    end

    // Outputs from the state.
    always_comb begin
        rvalid = 1'b0;
        err    = 1'b0;
        rdata  = '0;
        unique case (state_q)
            CSR_IDLE: ;
            CSR_READ_RESP: begin
                rvalid = 1'b1;
                rdata  = rdata_q;
            end
            CSR_FAULT_RESP: err = 1'b1;
            default: ;
        endcase
    end

    p_resp_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid && err));

    p_fault_zero_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> rdata == '0);

    p_read_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !$past(csr_valid)) |=> !rvalid);

endmodule

// File: rtl/intr_router.sv
module intr_router
    import intr_router_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int ADDR_W    = 12,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          dev_set,
    input  logic [LINE_W-1:0]             dev_set_line,
    input  logic                          dev_clr,
    input  logic [LINE_W-1:0]             dev_clr_line,
    output logic                          dev_clr_spurious,
    input  logic                          csr_valid,
    input  logic                          csr_write,
    input  logic [ADDR_W-1:0]             csr_addr,
    input  logic [1:0]                    csr_size,
    input  logic [NUM_LINES-1:0]          csr_wdata,
    output logic [NUM_LINES-1:0]          csr_rdata,
    output logic                          csr_rvalid,
    output logic                          csr_err,
    output logic [NUM_CPUS-1:0]           cpu_irq,
    output logic [NUM_CPUS*NUM_LINES-1:0] cpu_pending
);

    logic [NUM_LINES-1:0]          raw_q, raw_next;
    logic [NUM_CPUS*NUM_LINES-1:0] mask_all;
    logic [NUM_CPUS-1:0]           mask_we;

    intr_raw_vec #(.NUM_LINES(NUM_LINES)) u_raw (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vld  (dev_set),
        .set_idx  (dev_set_line),
        .clr_vld  (dev_clr),
        .clr_idx  (dev_clr_line),
        .raw_q    (raw_q),
        .raw_next (raw_next),
        .spur_q   (dev_clr_spurious)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        intr_cpu_slice #(.NUM_LINES(NUM_LINES)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_next   (raw_next),
            .mask_we    (mask_we[c]),
            .mask_wdata (csr_wdata),
            .mask_q     (mask_all[c*NUM_LINES +: NUM_LINES]),
            .pend_q     (cpu_pending[c*NUM_LINES +: NUM_LINES]),
            .irq_q      (cpu_irq[c])
        );

        p_pend_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_pending[c*NUM_LINES +: NUM_LINES] ==
            (raw_q & mask_all[c*NUM_LINES +: NUM_LINES]));
    end

    intr_csr_ctrl #(
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS),
        .ADDR_W    (ADDR_W)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_valid (csr_valid),
        .csr_write (csr_write),
        .csr_addr  (csr_addr),
        .csr_size  (csr_size),
        .raw_q     (raw_q),
        .mask_all  (mask_all),
        .pend_all  (cpu_pending),
        .mask_we   (mask_we),
        .rdata     (csr_rdata),
        .rvalid    (csr_rvalid),
        .err       (csr_err)
    );

    p_fault_no_mask_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csr_err |-> mask_all == $past(mask_all));

endmodule

// File: tb/intr_router_test.sv
`timescale 1ns/100ps
module intr_router_test;

    localparam int NL = 64;
    localparam int NC = 4;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_set = 1'b0, dev_clr = 1'b0;
    logic [5:0]    dev_set_line = '0, dev_clr_line = '0;
    logic          dev_clr_spurious;
    logic          csr_valid = 1'b0, csr_write = 1'b0;
    logic [AW-1:0] csr_addr = '0;
    logic [1:0]    csr_size = 2'd3;
    logic [NL-1:0] csr_wdata = '0;
    logic [NL-1:0] csr_rdata;
    logic          csr_rvalid, csr_err;
    logic [NC-1:0] cpu_irq;
    logic [NC*NL-1:0] cpu_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NL-1:0] m_raw;
    logic [NL-1:0] m_mask [NC];

    always #2.5 clk = ~clk;

    intr_router #(.NUM_LINES(NL), .NUM_CPUS(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .dev_set(dev_set), .dev_set_line(dev_set_line),
        .dev_clr(dev_clr), .dev_clr_line(dev_clr_line),
        .dev_clr_spurious(dev_clr_spurious),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_size(csr_size), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_rvalid(csr_rvalid), .csr_err(csr_err),
        .cpu_irq(cpu_irq), .cpu_pending(cpu_pending)
    );

    task automatic chk(string req, logic [NL-1:0] act, logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_legal(logic [AW-1:0] a, logic [1:0] sz, logic wr);
        int ix = int'(a >> 6);
        if (a[5:0] != 0 || sz != 2'd3 || ix > 2*NC) return 0;
        if (wr && (ix == 0 || ix > NC)) return 0;
        return 1;
    endfunction

    function automatic logic [NL-1:0] reg_val(logic [AW-1:0] a);
        int ix = int'(a >> 6);
        if (ix == 0) return m_raw;
        if (ix <= NC) return m_mask[ix-1];
        return m_raw & m_mask[ix-1-NC];
    endfunction

    // One clock: model the edge, then compare every output.
    task automatic tick();
        bit exp_spur, exp_rv, exp_err, lg;
        logic [NL-1:0] exp_rd;
        @(posedge clk);
        #1;
        exp_spur = dev_clr && !m_raw[dev_clr_line];
        lg       = is_legal(csr_addr, csr_size, csr_write);
        exp_rv   = csr_valid && lg && !csr_write;
        exp_err  = csr_valid && !lg;
        exp_rd   = exp_rv ? reg_val(csr_addr) : '0;
        if (dev_clr) m_raw[dev_clr_line] = 1'b0;
        if (dev_set) m_raw[dev_set_line] = 1'b1;
        if (csr_valid && lg && csr_write) m_mask[int'(csr_addr >> 6) - 1] = csr_wdata;
        chk("R3 spurious flag", NL'(dev_clr_spurious), NL'(exp_spur));
        chk("R7 R10 rvalid", NL'(csr_rvalid), NL'(exp_rv));
        chk("R8 R9 err", NL'(csr_err), NL'(exp_err));
        chk("R6 R7 R9 rdata", csr_rdata, exp_rd);
        for (int c = 0; c < NC; c++) begin
            chk("R4 pending", cpu_pending[c*NL +: NL], m_raw & m_mask[c]);
            chk("R5 irq", NL'(cpu_irq[c]), NL'(|(m_raw & m_mask[c])));
        end
        dev_set = 0; dev_clr = 0; csr_valid = 0; csr_write = 0;
        csr_size = 2'd3; csr_addr = '0;
    endtask

    task automatic csr(bit wr, int ix, logic [NL-1:0] d);
        csr_valid = 1; csr_write = wr; csr_addr = AW'(ix << 6); csr_wdata = d;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_raw = '0;
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        void'($urandom(32'h1d2c3b4a));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R11: reset state
        chk("R11 reset pending", cpu_pending[NL-1:0] | cpu_pending[NC*NL-1 -: NL], '0);
        chk("R11 reset flags", NL'({cpu_irq, csr_rvalid, csr_err, dev_clr_spurious}), '0);

        // R1: set line 5 with no masks, then read raw
        dev_set = 1; dev_set_line = 6'd5; tick();
        csr(0, 0, '0); tick();
        chk("R1 raw read bit5", csr_rdata, 64'h20);
        // R4 R10: enable line 5 and 63 for CPU 1, pend follows
        csr(1, 2, 64'h8000_0000_0000_0020); tick();
        // R4: same-cycle set line 63 and mask write on CPU 2
        dev_set = 1; dev_set_line = 6'd63; csr(1, 3, 64'h8000_0000_0000_0000); tick();
        chk("R4 combined cpu2", cpu_pending[2*NL +: NL], 64'h8000_0000_0000_0000);
        // R2: same line set and clear, set wins
        dev_set = 1; dev_set_line = 6'd7; dev_clr = 1; dev_clr_line = 6'd7; tick();
        csr(0, 0, '0); tick();
        chk("R2 set wins", csr_rdata & 64'h80, 64'h80);
        dev_clr = 1; dev_clr_line = 6'd5; tick();
        chk("R2 clear line5 cpu1", cpu_pending[NL +: NL], 64'h8000_0000_0000_0000);
        // R3: spurious clear of line 5
        dev_clr = 1; dev_clr_line = 6'd5; tick();
        // R9: writes to raw and pending, misaligned, narrow, unmapped
        csr(1, 0, '1); tick();
        csr(1, NC+1, '1); tick();
        csr(1, 1, '1); csr_addr = AW'(64 + 8); tick();
        csr(1, 1, '1); csr_size = 2'd2; tick();
        csr(0, 2*NC+1, '0); tick();
        // R6: read each mask and pending register
        for (int ix = 1; ix <= 2*NC; ix++) begin csr(0, ix, '0); tick(); end

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            if ($urandom_range(0, 2) == 0) begin dev_set = 1; dev_set_line = 6'($urandom); end
            if ($urandom_range(0, 2) == 0) begin dev_clr = 1; dev_clr_line = 6'($urandom); end
            r = $urandom_range(0, 9);
            if (r < 5) begin
                csr(r < 2, $urandom_range(0, 2*NC+2), {$urandom, $urandom} & {$urandom, $urandom});
                if ($urandom_range(0, 9) == 0) csr_addr[5:0] = 6'($urandom);
                if ($urandom_range(0, 9) == 0) csr_size = 2'($urandom);
            end
            tick();
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule